// File: doc/BRIEF.md
# Per-Bank Open-Row Tracker

This block sits beside an SDRAM command sequencer. It records which row, if any, is open in each of the four banks of the device. It also classifies every access request against that record. A request carries a linear byte address. The block splits that address into bank, row and column fields, using two configuration inputs: the row size (256 or 512 bytes) and the device size (2, 4 or 8 MB). It then reports whether the access needs only a column command, an activate, or a precharge followed by an activate. The result is registered and appears one cycle after the request.

Rows are never closed on the block's own initiative. Each bank slot is a two-state machine:
- **SLOT_CLOSED** moves to **SLOT_OPEN** on an activate to that bank.
- **SLOT_OPEN** stays in **SLOT_OPEN** on a further activate, which only loads the new row.
- **SLOT_OPEN** returns to **SLOT_CLOSED** on a precharge to that bank, a precharge-all, or a refresh.

The sequencer reports one event per cycle on a 3-bit code. A request presented in the same cycle as an event is judged against the table after that event has been applied.

Top module: `bank_row_tracker`

## Requirements
- R1: Each of the four banks holds its own row. An activate event (code 1) on `ev_bank` opens that bank with `ev_row` and leaves the other three banks unchanged.
- R2: Rows stay open. The table changes only on event codes 1 to 4. Code 0 and codes 5 to 7 have no effect, and no request closes a row.
- R3: A request whose bank is open with the same row is reported as kind 0, a row hit.
- R4: A request to a bank with no open row is reported as kind 1, activate needed.
- R5: A request to a bank that is open with a different row is reported as kind 2, a row conflict (precharge, then activate).
- R6: A precharge event (code 2) closes only the bank given on `ev_bank`.
- R7: A precharge-all event (code 3) or a refresh event (code 4) closes all four banks.
- R8: Address mapping follows `cfg_row512`. A value of 0 gives 256-byte rows and 1 gives 512-byte rows. The byte offset inside the row occupies the low 8 or 9 address bits. The two bank bits sit directly above the offset, and the row number sits above the bank bits. `res_col` is the byte offset divided by two, because the device port is 2 bytes wide and each 4-byte word covers two column locations.
- R9: `cfg_mem_sel` selects the device size: 0 gives 2 MB, 1 gives 4 MB, and 2 or 3 give 8 MB. Address bits at or above the selected size are ignored.
- R10: `res_valid` equals `req_valid` of the previous cycle. The other outputs of a valid result describe the request from that cycle, judged after any event presented in the same cycle.
- R11: After reset all banks are closed and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_row512 | input | 1 | Row size select: 0 = 256 B, 1 = 512 B |
| cfg_mem_sel | input | 2 | Device size: 0 = 2 MB, 1 = 4 MB, 2/3 = 8 MB |
| req_valid | input | 1 | Request present |
| req_addr | input | 23 | Linear byte address of the request |
| ev_op | input | 3 | Event: 0 none, 1 activate, 2 precharge, 3 precharge-all, 4 refresh |
| ev_bank | input | 2 | Bank of an activate or precharge event |
| ev_row | input | 13 | Row opened by an activate event |
| res_valid | output | 1 | Result valid (one cycle after the request) |
| res_kind | output | 2 | 0 hit, 1 activate needed, 2 conflict |
| res_bank | output | 2 | Bank field of the request |
| res_row | output | 13 | Row field of the request |
| res_col | output | 8 | Column (16-bit location) of the request |

## Verification
A table update and a request classification can fall in the same cycle. An activate, precharge, precharge-all or refresh may arrive together with a request to the affected bank, and the answer must already reflect the new table. The bench provokes this with directed cases, for example an activate alongside a request to the same row, or a precharge-all alongside a request to an open bank. Random cycles also drive events and requests together on purpose. Each result is judged against a bench model that applies the event first and then classifies the request with its own division-based address split.

// File: rtl/brt_pkg.sv
package brt_pkg;

    // Event codes reported by the command sequencer
    localparam logic [2:0] EV_NONE = 3'd0;
    localparam logic [2:0] EV_ACT  = 3'd1;
    localparam logic [2:0] EV_PRE  = 3'd2;
    localparam logic [2:0] EV_PALL = 3'd3;
    localparam logic [2:0] EV_REF  = 3'd4;

    // Classification of a request
    typedef enum logic [1:0] {
        K_HIT  = 2'd0,
        K_ACT  = 2'd1,
        K_CONF = 2'd2
    } kind_e;

    // State of one bank slot
    typedef enum logic {
        SLOT_CLOSED = 1'b0,
        SLOT_OPEN   = 1'b1
    } slot_e;

endpackage

// File: rtl/brt_addr_split.sv
module brt_addr_split #(
    parameter int ADDR_W       = 23,
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 8,
    parameter int MIN_ROW_LOG2 = 8,
    parameter int MIN_MEM_LOG2 = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              row512,
    input  logic [1:0]        mem_sel,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

    int                size_log2;
    int                off_w;
    logic [ADDR_W-1:0] masked;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        unique case (mem_sel)
            2'd0:    size_log2 = MIN_MEM_LOG2;
            2'd1:    size_log2 = MIN_MEM_LOG2 + 1;
            default: size_log2 = MIN_MEM_LOG2 + 2;
        endcase
        off_w  = MIN_ROW_LOG2 + (row512 ? 1 : 0);
        masked = addr & (ONES >> (ADDR_W - size_log2));
        offset = masked & ~(ONES << off_w);
        col    = COL_W'(offset >> 1);
        bank   = BANK_W'(masked >> off_w);
        row    = ROW_W'(masked >> (off_w + BANK_W));
    end

endmodule

// File: rtl/brt_bank_slot.sv
module brt_bank_slot
    import brt_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic             open_nx,
    output logic [ROW_W-1:0] row_nx
);

    slot_e            state_q;
    slot_e            state_d;
    logic [ROW_W-1:0] row_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_CLOSED;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_nx;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_CLOSED: if (act_i)   state_d = SLOT_OPEN;
            SLOT_OPEN:   if (close_i) state_d = SLOT_CLOSED;
            default:     state_d = SLOT_CLOSED;
        endcase
    end

    // Outputs
    always_comb begin
        is_open = (state_q == SLOT_OPEN);
        open_nx = (state_d == SLOT_OPEN);
        row_nx  = act_i ? row_in : row_q;
    end

endmodule

// File: rtl/brt_classify.sv
module brt_classify
    import brt_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 8,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [NBANK-1:0]  open_nx,
    input  logic [ROW_W-1:0]  rows_nx [NBANK],
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [BANK_W-1:0] res_bank,
    output logic [ROW_W-1:0]  res_row,
    output logic [COL_W-1:0]  res_col
);

    kind_e kind_d;

    always_comb begin
        if (!open_nx[bank])
            kind_d = K_ACT;
        else if (rows_nx[bank] == row)
            kind_d = K_HIT;
        else
            kind_d = K_CONF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_kind  <= K_ACT;
            res_bank  <= '0;
            res_row   <= '0;
            res_col   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_kind <= kind_d;
                res_bank <= bank;
                res_row  <= row;
                res_col  <= col;
            end
        end
    end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import brt_pkg::*;
#(
    parameter int  BANK_W       = 2,
    parameter int  MIN_ROW_LOG2 = 8,
    parameter int  MIN_MEM_LOG2 = 21,
    localparam int NBANK        = 1 << BANK_W,
    localparam int ADDR_W       = MIN_MEM_LOG2 + 2,
    localparam int ROW_W        = ADDR_W - MIN_ROW_LOG2 - BANK_W,
    localparam int COL_W        = MIN_ROW_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_row512,
    input  logic [1:0]        cfg_mem_sel,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        ev_op,
    input  logic [BANK_W-1:0] ev_bank,
    input  logic [ROW_W-1:0]  ev_row,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [BANK_W-1:0] res_bank,
    output logic [ROW_W-1:0]  res_row,
    output logic [COL_W-1:0]  res_col
);

    logic              is_act;
    logic              is_pre;
    logic              is_all;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic [NBANK-1:0]  open_vec;
    logic [NBANK-1:0]  open_nx;
    logic [ROW_W-1:0]  rows_nx [NBANK];

    always_comb begin
        is_act = (ev_op == EV_ACT);
        is_pre = (ev_op == EV_PRE);
        is_all = (ev_op == EV_PALL) || (ev_op == EV_REF);
    end

    brt_addr_split #(
        .ADDR_W      (ADDR_W),
        .BANK_W      (BANK_W),
        .ROW_W       (ROW_W),
        .COL_W       (COL_W),
        .MIN_ROW_LOG2(MIN_ROW_LOG2),
        .MIN_MEM_LOG2(MIN_MEM_LOG2)
    ) u_split (
        .addr   (req_addr),
        .row512 (cfg_row512),
        .mem_sel(cfg_mem_sel),
        .bank   (req_bank),
        .row    (req_row),
        .col    (req_col)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_slot
        logic sel;
        assign sel = (ev_bank == BANK_W'(g));
        brt_bank_slot #(
            .ROW_W(ROW_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_i  (is_act && sel),
            .close_i(is_all || (is_pre && sel)),
            .row_in (ev_row),
            .is_open(open_vec[g]),
            .open_nx(open_nx[g]),
            .row_nx (rows_nx[g])
        );
    end

    brt_classify #(
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .bank     (req_bank),
        .row      (req_row),
        .col      (req_col),
        .open_nx  (open_nx),
        .rows_nx  (rows_nx),
        .res_valid(res_valid),
        .res_kind (res_kind),
        .res_bank (res_bank),
        .res_row  (res_row),
        .res_col  (res_col)
    );

endmodule

// File: rtl/brt_chk.sv
module brt_chk #(
    parameter int BANK_W = 2,
    localparam int NBANK = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        ev_op,
    input logic [BANK_W-1:0] ev_bank,
    input logic [NBANK-1:0]  open_vec,
    input logic              res_valid,
    input logic [1:0]        res_kind
);

    // R1
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_op == 3'd1) |=> open_vec[$past(ev_bank)]);

    // R2
    no_event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_op == 3'd0 || ev_op > 3'd4) |=> $stable(open_vec));

    // R6
    pre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_op == 3'd2) |=> (!open_vec[$past(ev_bank)]
                             && $countones(open_vec ^ $past(open_vec)) <= 1));

    // R7
    all_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_op == 3'd3 || ev_op == 3'd4) |=> (open_vec == '0));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R10
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R5
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_kind != 2'd3));

endmodule

bind bank_row_tracker brt_chk #(.BANK_W(BANK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .ev_op    (ev_op),
    .ev_bank  (ev_bank),
    .open_vec (open_vec),
    .res_valid(res_valid),
    .res_kind (res_kind)
);

// File: tb/bank_row_tracker_test.sv
module bank_row_tracker_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_row512;
    logic [1:0]  cfg_mem_sel;
    logic        req_valid;
    logic [22:0] req_addr;
    logic [2:0]  ev_op;
    logic [1:0]  ev_bank;
    logic [12:0] ev_row;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [1:0]  res_bank;
    logic [12:0] res_row;
    logic [7:0]  res_col;

    int n_chk = 0;
    int n_bad = 0;
    bit m_open [4];
    int m_row  [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_row_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_row512(cfg_row512), .cfg_mem_sel(cfg_mem_sel),
        .req_valid(req_valid), .req_addr(req_addr), .ev_op(ev_op), .ev_bank(ev_bank),
        .ev_row(ev_row), .res_valid(res_valid), .res_kind(res_kind), .res_bank(res_bank),
        .res_row(res_row), .res_col(res_col)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int rbytes();
        return cfg_row512 ? 512 : 256;
    endfunction

    function automatic int msize();
        return (cfg_mem_sel == 2'd0) ? (1 << 21) : (cfg_mem_sel == 2'd1) ? (1 << 22) : (1 << 23);
    endfunction

    function automatic logic [22:0] mk_addr(input int row, input int bank, input int cb);
        return 23'((row * 4 + bank) * rbytes() + cb);
    endfunction

    // One cycle: drive at a falling edge, check the result at the next one.
    task automatic step(input bit rv, input logic [22:0] a, input logic [2:0] op,
                        input int b, input int r, input string tag);
        int m, ebk, erow, ecol, ekind;
        req_valid = rv; req_addr = a; ev_op = op;
        ev_bank = 2'(b); ev_row = 13'(r);
        case (op)
            3'd1: begin m_open[b] = 1'b1; m_row[b] = r; end
            3'd2: m_open[b] = 1'b0;
            3'd3, 3'd4: for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
            default: ;
        endcase
        m    = int'(a) % msize();
        ebk  = (m / rbytes()) % 4;
        erow = m / (rbytes() * 4);
        ecol = (m % rbytes()) / 2;
        ekind = !m_open[ebk] ? 1 : (m_row[ebk] == erow) ? 0 : 2;
        @(posedge clk);
        @(negedge clk);
        chk(res_valid == rv, tag, "res_valid", res_valid, rv);
        if (rv) begin
            chk(res_kind == 2'(ekind), tag, "res_kind", res_kind, ekind);
            chk(res_bank == 2'(ebk), tag, "res_bank", res_bank, ebk);
            chk(res_row == 13'(erow), tag, "res_row", res_row, erow);
            chk(res_col == 8'(ecol), tag, "res_col", res_col, ecol);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(7);
        rst_n = 1'b0; cfg_row512 = 1'b0; cfg_mem_sel = 2'd2;
        req_valid = 1'b0; req_addr = '0; ev_op = '0; ev_bank = '0; ev_row = '0;
        for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_row[i] = 0; end
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R11", "res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        // R11: every bank starts closed
        for (int b = 0; b < 4; b++) step(1, mk_addr(0, b, 0), 3'd0, 0, 0, "R11");
        // R10: no request, no result
        step(0, '0, 3'd1, 0, 5, "R10");
        step(1, mk_addr(5, 0, 16), 3'd0, 0, 0, "R3");
        step(1, mk_addr(5, 0, 200), 3'd0, 0, 0, "R2");
        step(1, mk_addr(6, 0, 4), 3'd0, 0, 0, "R5");
        step(1, mk_addr(9, 1, 0), 3'd0, 0, 0, "R4");
        // R1 / R10: activate and request in the same cycle
        step(1, mk_addr(9, 1, 8), 3'd1, 1, 9, "R10");
        step(1, mk_addr(5, 0, 0), 3'd0, 0, 0, "R1");
        step(1, mk_addr(9, 1, 2), 3'd2, 0, 0, "R6");
        step(1, mk_addr(5, 0, 2), 3'd0, 0, 0, "R6");
        step(1, mk_addr(9, 1, 2), 3'd3, 0, 0, "R7");
        step(0, '0, 3'd1, 2, 33, "R7");
        step(1, mk_addr(33, 2, 0), 3'd4, 0, 0, "R7");
        step(0, '0, 3'd1, 3, 4, "R2");
        step(1, mk_addr(4, 3, 6), 3'd6, 3, 0, "R2");
        // R8: 512-byte rows, last column
        cfg_row512 = 1'b1;
        step(0, '0, 3'd1, 3, 2, "R8");
        step(1, mk_addr(2, 3, 510), 3'd0, 0, 0, "R8");
        // R9: 2 MB ignores address bits 21 and 22
        cfg_mem_sel = 2'd0;
        step(1, mk_addr(2, 3, 4) | 23'h600000, 3'd0, 0, 0, "R9");
        cfg_mem_sel = 2'd3;
        step(1, mk_addr(2, 3, 4) | 23'h400000, 3'd0, 0, 0, "R9");
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int opr;
            logic [2:0] op;
            logic [22:0] a;
            if (n % 500 == 0) begin
                cfg_row512  = 1'($urandom);
                cfg_mem_sel = 2'($urandom);
            end
            opr = int'($urandom % 10);
            op  = (opr < 3) ? 3'd1 : (opr == 3) ? 3'd2 : (opr == 4) ? ((opr % 2 == 0) ? 3'd3 : 3'd4)
                : (opr == 5) ? 3'(5 + $urandom % 3) : 3'd0;
            if (n % 97 == 0) op = 3'd4;
            a = mk_addr(int'($urandom % 4), int'($urandom % 4), int'($urandom % rbytes()));
            if (cfg_mem_sel == 2'd0) a = a | 23'(($urandom % 4) << 21);
            step(1'($urandom % 4 != 0), a, op, int'($urandom % 4), int'($urandom % 4),
                 "R3 R4 R5 R10 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule